// File: doc/BRIEF.md
# I2C Dual Slave Address Matcher

This block listens to an I2C bus as a slave and decides whether the address byte that follows each START names this device. Two 7-bit addresses can be programmed: a primary one and a second one. A format selection decides which of the two take part in recognition. It can also switch recognition off completely when the serial port runs a clocked synchronous format.

The format selection is made of three bits. The first is a switch bit, given as an input pin. The second is a format bit in bit 0 of the primary address register. The third is a format bit in bit 0 of the second address register. Bits 7 to 1 of each register hold the address itself.

A small register port writes and reads the address registers. The second address register shares its port location with a data register. The interface-enable input decides which of the two an access reaches.

When an address matches, the block produces:
- a one-cycle match pulse;
- a flag saying whether the second address was the one that hit;
- the received R/W bit;
- an ACK request that covers the ninth SCL clock.

The SCL and SDA inputs are assumed to be already synchronised to `clk`.

Top module: `i2c_dual_addr_match`

## Requirements
- R1: After reset, the primary address register reads 0x00 and the second address register reads 0x01 (address 0, second format bit 1). `match_pulse` and `ack_req` are low.
- R2: With `reg_sel`=1 and `if_en`=0, writes and reads reach the second address register. With `if_en`=1 they reach the data register, and the second address register keeps its value. `reg_sel`=0 always reaches the primary address register. `reg_rdata` shows the selected register in the same cycle.
- R3: With `mode_sw`=0, the pair {primary bit 0, second bit 0} selects the mode. 00 enables both addresses. 01 enables the primary address only. 10 enables the second address only. 11 is synchronous serial format, in which neither address is enabled.
- R4: While `mode_sw`=1, `match_pulse` is never asserted.
- R5: A match occurs when bits 7..1 of the first byte after a START (received MSB first, sampled at SCL rising edges) equal bits 7..1 of an enabled address register. `match_pulse` is high for exactly the one clock cycle that follows the clock edge at which the eighth SCL rise is first sampled.
- R6: If both addresses match, the primary address wins and `match_second`=0. If only the second address matches, `match_second`=1.
- R7: `rw_bit` holds bit 0 of the matched byte.
- R8: After a match, `ack_req` rises in the cycle after the SCL fall that ends bit 8 is sampled. It falls in the cycle after the SCL fall that ends the ninth clock is sampled. It never rises without a match.
- R9: A START received in the middle of an address byte discards the bits captured so far and begins a new capture.
- R10: While `if_en`=0, no match is declared.
- R11: Bytes that follow the address byte without a new START never produce a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_in | input | 1 | Synchronised SCL level |
| sda_in | input | 1 | Synchronised SDA level |
| if_en | input | 1 | Interface enable; also steers the shared register location |
| mode_sw | input | 1 | Switch bit of the format selection |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = primary address register, 1 = shared second-address/data location |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Contents of the selected register |
| match_pulse | output | 1 | One-cycle address match pulse |
| match_second | output | 1 | 1 when the second address produced the match |
| rw_bit | output | 1 | R/W bit of the matched address byte |
| ack_req | output | 1 | Request to hold SDA low for the ninth clock |

## Verification
The results of this block are due at known delays:
- The match pulse and its flags are registered from the edge that samples the eighth SCL rise, so the bench reads them one clock period after it raises SCL. It reads the pulse again one period later and expects it to be gone.
- The ACK request follows the edge that samples the SCL fall, so it is read one period after SCL is driven low. It is read again after the ninth-clock fall to confirm release.
- Register reads are combinational and are taken one period after the select changes.

The bench drives every input on the falling clock edge and samples only there, so each check falls on a whole number of periods after its stimulus.

// File: rtl/i2cam_pkg.sv
// Package: types shared by the address matcher.
// Assumes: the format selection comes from three bits (switch, primary fs, second fs).
package i2cam_pkg;

    typedef enum logic [1:0] {
        FMT_BOTH = 2'd0,
        FMT_PRIM = 2'd1,
        FMT_SEC  = 2'd2,
        FMT_NONE = 2'd3
    } fmt_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_WAITF = 3'd2,
        ST_ACK   = 3'd3,
        ST_DONE  = 3'd4
    } cap_st_t;

    // Map switch + format bits to an addressing format.
    function automatic fmt_t fmt_decode(input logic sw, input logic fs_p, input logic fs_s);
        fmt_t f;
        if (sw) begin
            f = FMT_NONE;
        end else begin
            case ({fs_p, fs_s})
                2'b00:   f = FMT_BOTH;
                2'b01:   f = FMT_PRIM;
                2'b10:   f = FMT_SEC;
                default: f = FMT_NONE;
            endcase
        end
        return f;
    endfunction

endpackage

// File: rtl/i2cam_line_mon.sv
// Module: bus line monitor.
// Keeps the previous SCL/SDA level and flags SCL edges and START conditions.
// Assumes: inputs are already synchronised to clk; an idle bus is high.
module i2cam_line_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det
);
    logic scl_q;
    logic sda_q;

    // Hold last-cycle line levels; reset to idle-high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
        end
    end

    // Edge and START flags from previous vs current level.
    always_comb begin
        scl_rise  = scl_in & ~scl_q;
        scl_fall  = ~scl_in & scl_q;
        start_det = scl_in & scl_q & sda_q & ~sda_in;
    end
endmodule

// File: rtl/i2cam_capture.sv
// Module: address byte capture and ACK sequencing.
// Shifts in bits at SCL rises after a START, reports byte completion, and
// sequences the ACK window over the ninth clock when the match logic reports a hit.
// Assumes: hit is valid in the same cycle as byte_done.
module i2cam_capture #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          sda_in,
    input  logic          hit,
    output logic          byte_done,
    output logic [AW:0]   rx_byte,
    output logic          ack_req
);
    import i2cam_pkg::*;

    localparam int BYTE_BITS = AW + 1;
    localparam int CNT_W     = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS - 1);

    cap_st_t          st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [AW-1:0]    shreg_q;

    // Byte completes on the last SCL rise of the address phase.
    always_comb begin
        rx_byte   = {shreg_q, sda_in};
        byte_done = (st_q == ST_ADDR) && scl_rise && (cnt_q == LAST_BIT) && !start_det;
        ack_req   = (st_q == ST_ACK);
    end

    // Capture state machine; a START restarts from any state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            cnt_q   <= '0;
            shreg_q <= '0;
        end else if (start_det) begin
            st_q  <= ST_ADDR;
            cnt_q <= '0;
        end else begin
            case (st_q)
                ST_ADDR: begin
                    if (scl_rise) begin
                        shreg_q <= rx_byte[AW-1:0];
                        cnt_q   <= cnt_q + 1'b1;
                        if (cnt_q == LAST_BIT) begin
                            st_q <= hit ? ST_WAITF : ST_DONE;
                        end
                    end
                end
                ST_WAITF: if (scl_fall) st_q <= ST_ACK;
                ST_ACK:   if (scl_fall) st_q <= ST_DONE;
                default:  st_q <= st_q;
            endcase
        end
    end
endmodule

// File: rtl/i2cam_match.sv
// Module: address comparison and registered match outputs.
// Compares the captured byte against the enabled addresses; primary wins ties.
// Assumes: enables already include the interface enable.
module i2cam_match #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_done,
    input  logic [AW:0]   rx_byte,
    input  logic [AW-1:0] prim_addr,
    input  logic [AW-1:0] sec_addr,
    input  logic          en_prim,
    input  logic          en_sec,
    output logic          hit,
    output logic          match_pulse,
    output logic          match_second,
    output logic          rw_bit
);
    logic p_hit;
    logic s_hit;

    // Compare the upper bits of the byte with each enabled address.
    always_comb begin
        p_hit = en_prim && (rx_byte[AW:1] == prim_addr);
        s_hit = en_sec  && (rx_byte[AW:1] == sec_addr);
        hit   = p_hit || s_hit;
    end

    // Register the pulse and latch which address hit and the R/W bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_pulse  <= 1'b0;
            match_second <= 1'b0;
            rw_bit       <= 1'b0;
        end else begin
            match_pulse <= byte_done && hit;
            if (byte_done && hit) begin
                match_second <= !p_hit;
                rw_bit       <= rx_byte[0];
            end
        end
    end
endmodule

// File: rtl/i2cam_regs.sv
// Module: address/data register file.
// Primary address register at select 0. Select 1 reaches the second address
// register while the interface is disabled, and the data register otherwise.
// Assumes: single-cycle write strobe, combinational read.
module i2cam_regs #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          if_en,
    input  logic          reg_wr,
    input  logic          reg_sel,
    input  logic [AW:0]   reg_wdata,
    output logic [AW:0]   reg_rdata,
    output logic [AW:0]   prim_q,
    output logic [AW:0]   sec_q
);
    localparam logic [AW:0] SEC_RST = {{AW{1'b0}}, 1'b1};

    logic [AW:0] data_q;

    // Register writes, steered by select and interface enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prim_q <= '0;
            sec_q  <= SEC_RST;
            data_q <= '0;
        end else if (reg_wr) begin
            if (!reg_sel)    prim_q <= reg_wdata;
            else if (!if_en) sec_q  <= reg_wdata;
            else             data_q <= reg_wdata;
        end
    end

    // Read mux with the same steering as the writes.
    always_comb begin
        if (!reg_sel)    reg_rdata = prim_q;
        else if (!if_en) reg_rdata = sec_q;
        else             reg_rdata = data_q;
    end
endmodule

// File: rtl/i2c_dual_addr_match.sv
// Module: top of the dual slave address matcher.
// Decodes the addressing format and wires the monitor, capture, match and registers.
// Assumes: scl_in/sda_in are synchronised; recognition only while if_en=1.
module i2c_dual_addr_match #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_in,
    input  logic          sda_in,
    input  logic          if_en,
    input  logic          mode_sw,
    input  logic          reg_wr,
    input  logic          reg_sel,
    input  logic [AW:0]   reg_wdata,
    output logic [AW:0]   reg_rdata,
    output logic          match_pulse,
    output logic          match_second,
    output logic          rw_bit,
    output logic          ack_req
);
    import i2cam_pkg::*;

    logic        scl_rise, scl_fall, start_det;
    logic        byte_done, hit;
    logic [AW:0] rx_byte;
    logic [AW:0] prim_reg, sec_reg;
    logic        en_prim, en_sec;
    fmt_t        fmt;

    // Format decode to per-address enables.
    always_comb begin
        fmt     = fmt_decode(mode_sw, prim_reg[0], sec_reg[0]);
        en_prim = if_en && (fmt == FMT_BOTH || fmt == FMT_PRIM);
        en_sec  = if_en && (fmt == FMT_BOTH || fmt == FMT_SEC);
    end

    i2cam_line_mon u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det)
    );

    i2cam_capture #(.AW(AW)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .sda_in    (sda_in),
        .hit       (hit),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .ack_req   (ack_req)
    );

    i2cam_match #(.AW(AW)) u_match (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_done    (byte_done),
        .rx_byte      (rx_byte),
        .prim_addr    (prim_reg[AW:1]),
        .sec_addr     (sec_reg[AW:1]),
        .en_prim      (en_prim),
        .en_sec       (en_sec),
        .hit          (hit),
        .match_pulse  (match_pulse),
        .match_second (match_second),
        .rw_bit       (rw_bit)
    );

    i2cam_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .if_en     (if_en),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .prim_q    (prim_reg),
        .sec_q     (sec_reg)
    );
endmodule

// File: rtl/i2cam_checker.sv
// Module: property checker bound to the matcher top.
// Assumes: it sees the second address register through the top's internal net.
module i2cam_checker #(
    parameter int AW = 7
) (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_in,
    input logic        if_en,
    input logic        mode_sw,
    input logic        match_pulse,
    input logic        ack_req,
    input logic [AW:0] sec_reg
);
    // R5: the match pulse lasts a single cycle.
    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |=> !match_pulse);

    // R4: no match while the reserved switch setting is applied.
    assert_no_match_sw_R4: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> !$past(mode_sw));

    // R10: no match while the interface is disabled.
    assert_no_match_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> $past(if_en));

    // R8: the ACK request begins only while SCL is low.
    assert_ack_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_req) |-> !scl_in);

    // R2: the second address register is frozen across an enabled cycle.
    assert_sec_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(if_en) |-> $stable(sec_reg));
endmodule

bind i2c_dual_addr_match i2cam_checker #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_in      (scl_in),
    .if_en       (if_en),
    .mode_sw     (mode_sw),
    .match_pulse (match_pulse),
    .ack_req     (ack_req),
    .sec_reg     (sec_reg)
);

// File: tb/sim_i2c_dual_addr_match.sv
// Bench: sweeps every addressing mode over all 128 addresses, then walks the corner cases.
module sim_i2c_dual_addr_match;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 190000;
    localparam logic [6:0] PA = 7'h2A;
    localparam logic [6:0] SA = 7'h55;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1, sda = 1'b1;
    logic       if_en = 1'b0, mode_sw = 1'b0;
    logic       reg_wr = 1'b0, reg_sel = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       match_pulse, match_second, rw_bit, ack_req;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_dual_addr_match u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
        .if_en(if_en), .mode_sw(mode_sw), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .match_pulse(match_pulse),
        .match_second(match_second), .rw_bit(rw_bit), .ack_req(ack_req)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic s, input logic [7:0] d);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1; step();
        reg_wr = 1'b0; step();
    endtask

    task automatic start_c();
        sda = 1'b1; step(); scl = 1'b1; step(); step();
        sda = 1'b0; step(); step(); scl = 1'b0; step();
    endtask

    task automatic stop_c();
        sda = 1'b0; step(); scl = 1'b1; step(); step();
        sda = 1'b1; step(); step();
    endtask

    task automatic clk_bit(input logic b);
        sda = b; step(); scl = 1'b1; step(); step(); scl = 1'b0; step();
    endtask

    // Send eight bits plus the ninth clock, checking match and ACK timing.
    task automatic send_byte(input logic [7:0] b, input logic exp, input logic exp_sec, input string req);
        for (int i = 7; i >= 1; i--) clk_bit(b[i]);
        sda = b[0]; step(); scl = 1'b1; step();
        check(req, match_pulse, exp);
        if (exp) begin
            check("R6", match_second, exp_sec);
            check("R7", rw_bit, b[0]);
        end
        step(); check("R5 pulse width", match_pulse, 1'b0);
        scl = 1'b0; step(); check("R8 ack start", ack_req, exp);
        sda = 1'b1; step(); scl = 1'b1; step(); step();
        check("R8 ack hold", ack_req, exp);
        scl = 1'b0; step(); check("R8 ack end", ack_req, 1'b0);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1; step();
        // R1: reset values
        reg_sel = 1'b1; step(); check("R1 second reg", reg_rdata, 8'h01);
        reg_sel = 1'b0; step(); check("R1 primary reg", reg_rdata, 8'h00);
        check("R1 pulse", match_pulse, 1'b0);
        check("R1 ack", ack_req, 1'b0);

        // R3/R4: sweep all {sw,fs,fsx} over all addresses
        for (int m = 0; m < 8; m++) begin
            if_en = 1'b0;
            wr(1'b0, {PA, m[1]});
            wr(1'b1, {SA, m[0]});
            if_en = 1'b1; mode_sw = m[2];
            for (int a = 0; a < 128; a++) begin
                logic [6:0] ad;
                logic ep, es;
                ad = 7'(a);
                ep = !m[2] && !m[1] && (ad == PA);
                es = !m[2] && !m[0] && (ad == SA);
                start_c();
                send_byte({ad, ad[0] ^ m[0]}, ep | es, !ep, m[2] ? "R4" : "R3");
                stop_c();
            end
        end
        mode_sw = 1'b0;

        // R6: both addresses equal, primary wins
        if_en = 1'b0; wr(1'b0, 8'h66); wr(1'b1, 8'h66); if_en = 1'b1;
        start_c(); send_byte(8'h67, 1'b1, 1'b0, "R6 both"); stop_c();

        // R10: disabled interface never matches; primary only mode
        if_en = 1'b0; wr(1'b0, {PA, 1'b0}); wr(1'b1, {SA, 1'b1});
        start_c(); send_byte({PA, 1'b0}, 1'b0, 1'b0, "R10"); stop_c();
        if_en = 1'b1;

        // R9: repeated START mid-byte restarts capture
        start_c();
        clk_bit(1'b1); clk_bit(1'b1); clk_bit(1'b0); clk_bit(1'b1);
        start_c(); send_byte({PA, 1'b1}, 1'b1, 1'b0, "R9"); stop_c();

        // R11: a following byte without START is ignored
        start_c(); send_byte({PA, 1'b0}, 1'b1, 1'b0, "R11 first");
        send_byte({PA, 1'b0}, 1'b0, 1'b0, "R11 second"); stop_c();

        // R2: shared location steering
        if_en = 1'b1; wr(1'b1, 8'hC3);
        reg_sel = 1'b1; step(); check("R2 data reg", reg_rdata, 8'hC3);
        if_en = 1'b0; step(); check("R2 second unchanged", reg_rdata, {SA, 1'b1});
        wr(1'b1, 8'h5A); step(); check("R2 second written", reg_rdata, 8'h5A);
        if_en = 1'b1; step(); check("R2 data kept", reg_rdata, 8'hC3);
        reg_sel = 1'b0; step(); check("R2 primary", reg_rdata, {PA, 1'b0});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule